// File: doc/BRIEF.md
# Paged Memory Controller with Scratchpad Staging

This block holds a paged memory array, 16 pages of 32 bytes by default, kept as a register file. Every write to the array goes through a row-sized scratchpad buffer. The host opens the scratchpad with a target address, streams bytes into it, and can read those bytes back. It then commits them with a copy request that must repeat the target address and the ending offset exactly. The host also reads the array directly, one byte per request.

Each page carries a two-bit protection mode:
- **Normal**: a copy overwrites the stored bytes.
- **Locked**: a copy leaves the page untouched.
- **Clear-only**: the stored byte becomes the old value ANDed with the new one, so bits can only fall from 1 to 0.

An accepted copy moves one byte per cycle. It then holds `busy` for a parameterised programming time. While `busy` is high, the block refuses new scratchpad activity and copy requests.

The sequencer has four states:
- **IDLE**: after reset and after every copy.
- **LOAD**: the scratchpad is open.
- **COPY**: one byte is merged into the array per cycle.
- **PROG**: the programming timer runs.

Its transitions are:
- IDLE or LOAD to LOAD on an accepted `ld_start`.
- IDLE or LOAD to COPY on a matching copy request.
- COPY to PROG when the ending offset has been written.
- PROG to IDLE when the timer expires.

Top module: `pmem_stage_ctrl`

## Requirements
- R1: After reset, every array byte reads 0xFF, every page mode reads 00, and `busy`, `cp_mismatch` and `req_reject` are low.
- R2: `ld_start` with address A (page in bits [8:5], offset in bits [4:0]) opens the scratchpad at A. Each later `ld_valid` byte goes to the next scratchpad index, starting at the offset. `tgt_addr` shows A, `end_off` shows the index of the last byte written, and `sp_rd_data` shows the scratchpad byte at `sp_rd_idx`.
- R3: Bytes arriving after index 31 has been written are dropped. `end_off` stays at 31 and lower scratchpad indices are unchanged.
- R4: A copy request whose address equals `tgt_addr` and whose ending offset equals `end_off`, made after at least one byte was loaded, writes scratchpad indices offset..end into that page of the array and leaves the page's other bytes untouched. `busy` rises the cycle after the request and stays high for (number of bytes + PROG_CYCLES) cycles.
- R5: A copy request with a differing address or ending offset, or with no byte loaded since the last `ld_start`, changes no array byte and leaves `busy` low. `cp_mismatch` pulses high for one cycle, in the cycle after the request.
- R6: A page in mode 01 (locked) keeps its contents through a copy. The copy still runs the full busy interval.
- R7: A page in mode 10 (clear-only) stores old AND new for each copied byte.
- R8: A mode write (`md_we`, `md_page`, `md_val`) takes effect only while the page is in mode 00 and the value is not 11. Any page that is out of mode 00 keeps its mode for good. `md_rd_val` shows the mode of `md_rd_page`.
- R9: While `busy` is high, `ld_start`, `ld_valid` and `cp_req` have no effect on the scratchpad or the array, and `req_reject` pulses high in the cycle after each refused `ld_start` or `cp_req`.
- R10: An accepted copy consumes the scratchpad. Repeating the same copy request without a new load is treated as a mismatch.
- R11: `mr_data` shows the array byte at the `mr_addr` sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Open the scratchpad at `ld_addr` |
| ld_addr | input | 9 | Target address: page [8:5], offset [4:0] |
| ld_valid | input | 1 | Scratchpad byte strobe |
| ld_data | input | 8 | Scratchpad byte |
| sp_rd_idx | input | 5 | Scratchpad readback index |
| sp_rd_data | output | 8 | Scratchpad byte at `sp_rd_idx` |
| tgt_addr | output | 9 | Captured target address |
| end_off | output | 5 | Index of the last scratchpad byte written |
| cp_req | input | 1 | Copy request |
| cp_addr | input | 9 | Address repeated for the copy |
| cp_eoff | input | 5 | Ending offset repeated for the copy |
| mr_addr | input | 9 | Array read address |
| mr_data | output | 8 | Array read data, one cycle later |
| md_we | input | 1 | Page mode write strobe |
| md_page | input | 4 | Page whose mode is written |
| md_val | input | 2 | New mode: 00 normal, 01 locked, 10 clear-only |
| md_rd_page | input | 4 | Page whose mode is shown |
| md_rd_val | output | 2 | Mode of `md_rd_page` |
| busy | output | 1 | Copy or programming in progress |
| cp_mismatch | output | 1 | One-cycle pulse after a rejected copy request |
| req_reject | output | 1 | One-cycle pulse after a request refused while busy |

## Verification
The bench builds the block with the default 16 pages of 32 bytes and with PROG_CYCLES set to 6 instead of the default 2,500,000 (10 ms at 250 MHz). The short programming time makes it possible to count the whole busy window exactly for each copy. It also lets the bench issue requests in the middle of that window and still finish several complete copies. Keeping the default page and row sizes puts the end-of-row drop at index 31 and the full 9-bit address split within reach of the checks.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        PM_NORM = 2'b00,
        PM_LOCK = 2'b01,
        PM_ZERO = 2'b10
    } pmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COPY,
        ST_PROG
    } ctl_state_e;

endpackage

// File: rtl/pmem_mode_tab.sv
module pmem_mode_tab
    import pmem_pkg::*;
#(
    parameter int PAGES = 16,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [PG_W-1:0]      wr_page,
    input  logic [1:0]           wr_val,
    input  logic [PG_W-1:0]      rd_page,
    output logic [1:0]           rd_val,
    output logic [2*PAGES-1:0]   modes_flat
);

    logic [1:0] mode_q [PAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                mode_q[i] <= PM_NORM;
            end
        end else if (we && (mode_q[wr_page] == PM_NORM) && (wr_val != 2'b11)) begin
            mode_q[wr_page] <= wr_val;
        end
    end

    assign rd_val = mode_q[rd_page];

    for (genvar p = 0; p < PAGES; p++) begin : g_flat
        assign modes_flat[2*p +: 2] = mode_q[p];
    end

endmodule

// File: rtl/pmem_scratch.sv
module pmem_scratch #(
    parameter int ROW_BYTES = 32,
    parameter int ADDR_W    = 9,
    localparam int OFF_W    = $clog2(ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              consume,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte,
    input  logic [OFF_W-1:0]  cp_idx,
    output logic [7:0]        cp_byte,
    output logic [ADDR_W-1:0] tgt,
    output logic [OFF_W-1:0]  eoff,
    output logic              has_data
);

    localparam logic [OFF_W-1:0] LAST = OFF_W'(ROW_BYTES - 1);

    logic [7:0]        buf_q [ROW_BYTES];
    logic [OFF_W-1:0]  ptr_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_BYTES; i++) begin
                buf_q[i] <= 8'h00;
            end
            ptr_q    <= '0;
            full_q   <= 1'b0;
            tgt      <= '0;
            eoff     <= '0;
            has_data <= 1'b0;
        end else if (open_en) begin
            tgt      <= open_addr;
            ptr_q    <= open_addr[OFF_W-1:0];
            eoff     <= open_addr[OFF_W-1:0];
            full_q   <= 1'b0;
            has_data <= 1'b0;
        end else begin
            if (wr_en && !full_q) begin
                buf_q[ptr_q] <= wr_byte;
                eoff         <= ptr_q;
                has_data     <= 1'b1;
                if (ptr_q == LAST) begin
                    full_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
            if (consume) begin
                has_data <= 1'b0;
            end
        end
    end

    assign rd_byte = buf_q[rd_idx];
    assign cp_byte = buf_q[cp_idx];

endmodule

// File: rtl/pmem_array.sv
module pmem_array
    import pmem_pkg::*;
#(
    parameter int PAGES     = 16,
    parameter int ROW_BYTES = 32,
    localparam int DEPTH    = PAGES * ROW_BYTES,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [1:0]        wr_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
            rd_byte <= 8'hFF;
        end else begin
            if (wr_en) begin
                case (wr_mode)
                    PM_NORM: mem_q[wr_addr] <= wr_byte;
                    PM_ZERO: mem_q[wr_addr] <= mem_q[wr_addr] & wr_byte;
                    default: ;
                endcase
            end
            rd_byte <= mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/pmem_prog_timer.sv
module pmem_prog_timer #(
    parameter int PROG_CYCLES = 2500000,
    localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(PROG_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);

endmodule

// File: rtl/pmem_stage_ctrl.sv
module pmem_stage_ctrl
    import pmem_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int ROW_BYTES   = 32,
    parameter int PROG_CYCLES = 2500000,
    localparam int PG_W       = $clog2(PAGES),
    localparam int OFF_W      = $clog2(ROW_BYTES),
    localparam int ADDR_W     = PG_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_valid,
    input  logic [7:0]        ld_data,
    input  logic [OFF_W-1:0]  sp_rd_idx,
    output logic [7:0]        sp_rd_data,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [OFF_W-1:0]  end_off,
    input  logic              cp_req,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [OFF_W-1:0]  cp_eoff,
    input  logic [ADDR_W-1:0] mr_addr,
    output logic [7:0]        mr_data,
    input  logic              md_we,
    input  logic [PG_W-1:0]   md_page,
    input  logic [1:0]        md_val,
    input  logic [PG_W-1:0]   md_rd_page,
    output logic [1:0]        md_rd_val,
    output logic              busy,
    output logic              cp_mismatch,
    output logic              req_reject
);

    ctl_state_e state_q, state_d;

    logic [OFF_W-1:0]   idx_q;
    logic               sp_has;
    logic [7:0]         cp_byte;
    logic [2*PAGES-1:0] mode_flat;
    logic [PG_W-1:0]    tgt_page;
    logic [1:0]         arr_mode;
    logic               arr_we;
    logic               tmr_start;
    logic               tmr_run;
    logic               tmr_done;
    logic               ld_ok;
    logic               wr_ok;
    logic               cp_go;
    logic               cp_hit;
    logic               last_byte;
    logic               mismatch_q;
    logic               reject_q;

    assign busy      = (state_q == ST_COPY) || (state_q == ST_PROG);
    assign ld_ok     = ld_start && !busy;
    assign wr_ok     = ld_valid && !busy && !ld_start;
    assign cp_go     = cp_req && !busy && !ld_start;
    assign cp_hit    = cp_go && sp_has && (cp_addr == tgt_addr) && (cp_eoff == end_off);
    assign tgt_page  = tgt_addr[ADDR_W-1:OFF_W];
    assign arr_mode  = mode_flat[2*int'(tgt_page) +: 2];
    assign last_byte = (idx_q == end_off);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                if (ld_ok) begin
                    state_d = ST_LOAD;
                end else if (cp_hit) begin
                    state_d = ST_COPY;
                end
            end
            ST_COPY: begin
                if (last_byte) begin
                    state_d = ST_PROG;
                end
            end
            ST_PROG: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // state outputs
    always_comb begin
        arr_we    = 1'b0;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: ;
            ST_COPY: begin
                arr_we    = 1'b1;
                tmr_start = last_byte;
            end
            ST_PROG: tmr_run = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            mismatch_q <= 1'b0;
            reject_q   <= 1'b0;
        end else begin
            if (cp_hit) begin
                idx_q <= tgt_addr[OFF_W-1:0];
            end else if (state_q == ST_COPY) begin
                idx_q <= idx_q + 1'b1;
            end
            mismatch_q <= cp_go && !cp_hit;
            reject_q   <= busy && (ld_start || cp_req);
        end
    end

    assign cp_mismatch = mismatch_q;
    assign req_reject  = reject_q;

    pmem_scratch #(.ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W)) u_scratch (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (ld_ok),
        .open_addr(ld_addr),
        .wr_en    (wr_ok),
        .wr_byte  (ld_data),
        .consume  (cp_hit),
        .rd_idx   (sp_rd_idx),
        .rd_byte  (sp_rd_data),
        .cp_idx   (idx_q),
        .cp_byte  (cp_byte),
        .tgt      (tgt_addr),
        .eoff     (end_off),
        .has_data (sp_has)
    );

    pmem_array #(.PAGES(PAGES), .ROW_BYTES(ROW_BYTES)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (arr_we),
        .wr_addr({tgt_page, idx_q}),
        .wr_byte(cp_byte),
        .wr_mode(arr_mode),
        .rd_addr(mr_addr),
        .rd_byte(mr_data)
    );

    pmem_mode_tab #(.PAGES(PAGES)) u_modes (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (md_we),
        .wr_page   (md_page),
        .wr_val    (md_val),
        .rd_page   (md_rd_page),
        .rd_val    (md_rd_val),
        .modes_flat(mode_flat)
    );

    pmem_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .run  (tmr_run),
        .done (tmr_done)
    );

endmodule

// File: rtl/pmem_stage_ctrl_chk.sv
module pmem_stage_ctrl_chk #(
    parameter int PAGES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               ld_start,
    input logic               cp_req,
    input logic               req_reject,
    input logic               cp_mismatch,
    input logic               tmr_done,
    input logic [2*PAGES-1:0] mode_flat
);

    AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy && (ld_start || cp_req) |=> req_reject); // R9
    AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cp_mismatch |-> !busy); // R5
    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(tmr_done)); // R4

    for (genvar p = 0; p < PAGES; p++) begin : g_pg
        AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (mode_flat[2*p +: 2] != 2'b00) |=> $stable(mode_flat[2*p +: 2])); // R8
        AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mode_flat[2*p +: 2] != 2'b11); // R8
    end

endmodule

bind pmem_stage_ctrl pmem_stage_ctrl_chk #(.PAGES(PAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ld_start   (ld_start),
    .cp_req     (cp_req),
    .req_reject (req_reject),
    .cp_mismatch(cp_mismatch),
    .tmr_done   (tmr_done),
    .mode_flat  (mode_flat)
);

// File: tb/pmem_stage_ctrl_tb.sv
module pmem_stage_ctrl_tb;

    localparam int PC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_start = 1'b0;
    logic [8:0] ld_addr = '0;
    logic       ld_valid = 1'b0;
    logic [7:0] ld_data = '0;
    logic [4:0] sp_rd_idx = '0;
    logic [7:0] sp_rd_data;
    logic [8:0] tgt_addr;
    logic [4:0] end_off;
    logic       cp_req = 1'b0;
    logic [8:0] cp_addr = '0;
    logic [4:0] cp_eoff = '0;
    logic [8:0] mr_addr = '0;
    logic [7:0] mr_data;
    logic       md_we = 1'b0;
    logic [3:0] md_page = '0;
    logic [1:0] md_val = '0;
    logic [3:0] md_rd_page = '0;
    logic [1:0] md_rd_val;
    logic       busy;
    logic       cp_mismatch;
    logic       req_reject;

    always #2 clk = ~clk;

    pmem_stage_ctrl #(.PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
        .ld_valid(ld_valid), .ld_data(ld_data), .sp_rd_idx(sp_rd_idx),
        .sp_rd_data(sp_rd_data), .tgt_addr(tgt_addr), .end_off(end_off),
        .cp_req(cp_req), .cp_addr(cp_addr), .cp_eoff(cp_eoff),
        .mr_addr(mr_addr), .mr_data(mr_data), .md_we(md_we), .md_page(md_page),
        .md_val(md_val), .md_rd_page(md_rd_page), .md_rd_val(md_rd_val),
        .busy(busy), .cp_mismatch(cp_mismatch), .req_reject(req_reject)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];
    logic       rd_issue = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected array byte per issued read
    always @(posedge clk) begin
        if (rd_issue) begin
            #1;
            if (q_exp.size() > 0) begin
                chk(q_tag.pop_front(), int'(mr_data), int'(q_exp.pop_front()));
            end
        end
    end

    // driver: issue an array read and push its expected byte
    task automatic mem_expect(input int addr, input int exp, input string tag);
        q_exp.push_back(8'(exp));
        q_tag.push_back(tag);
        mr_addr  = 9'(addr);
        rd_issue = 1'b1;
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic ld_begin(input int addr);
        ld_start = 1'b1;
        ld_addr  = 9'(addr);
        @(negedge clk);
        ld_start = 1'b0;
    endtask

    task automatic ld_put(input int d);
        ld_valid = 1'b1;
        ld_data  = 8'(d);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic sp_expect(input int idx, input int exp, input string tag);
        sp_rd_idx = 5'(idx);
        #1;
        chk(tag, int'(sp_rd_data), exp);
        @(negedge clk);
    endtask

    task automatic copy_ok(input int addr, input int eoff, input int len, input string tag);
        int n;
        cp_req  = 1'b1;
        cp_addr = 9'(addr);
        cp_eoff = 5'(eoff);
        @(negedge clk);
        cp_req = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(tag, n, len);
    endtask

    task automatic copy_bad(input int addr, input int eoff, input string tag);
        cp_req  = 1'b1;
        cp_addr = 9'(addr);
        cp_eoff = 5'(eoff);
        @(negedge clk);
        cp_req = 1'b0;
        chk(tag, int'(cp_mismatch), 1);
        chk(tag, int'(busy), 0);
        @(negedge clk);
        chk(tag, int'(cp_mismatch), 0);
    endtask

    task automatic md_set(input int page, input int val);
        md_we   = 1'b1;
        md_page = 4'(page);
        md_val  = 2'(val);
        @(negedge clk);
        md_we = 1'b0;
    endtask

    task automatic md_expect(input int page, input int exp, input string tag);
        md_rd_page = 4'(page);
        #1;
        chk(tag, int'(md_rd_val), exp);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 mismatch", int'(cp_mismatch), 0);
        chk("R1 reject", int'(req_reject), 0);
        md_expect(9, 0, "R1 mode");
        mem_expect(0, 8'hFF, "R1 mem first");
        mem_expect(511, 8'hFF, "R1 mem last");

        // R2 / R4 / R11: page 3 offset 4, four bytes
        ld_begin(9'h064);
        ld_put(8'hA0); ld_put(8'hA1); ld_put(8'hA2); ld_put(8'hA3);
        chk("R2 tgt", int'(tgt_addr), 9'h064);
        chk("R2 end", int'(end_off), 7);
        sp_expect(4, 8'hA0, "R2 sp4");
        sp_expect(7, 8'hA3, "R2 sp7");
        copy_ok(9'h064, 7, 4 + PC, "R4 busy len");
        mem_expect(100, 8'hA0, "R4 mem");
        mem_expect(103, 8'hA3, "R11 mem");
        mem_expect(99, 8'hFF, "R4 below");
        mem_expect(104, 8'hFF, "R4 above");

        // R3: row end at page 5 offset 30
        ld_begin(9'h0BE);
        ld_put(8'h11); ld_put(8'h22); ld_put(8'h33); ld_put(8'h44);
        chk("R3 end", int'(end_off), 31);
        sp_expect(31, 8'h22, "R3 sp31");
        sp_expect(0, 8'h00, "R3 no wrap");
        copy_ok(9'h0BE, 31, 2 + PC, "R3 busy len");
        mem_expect(190, 8'h11, "R3 mem30");
        mem_expect(191, 8'h22, "R3 mem31");
        mem_expect(160, 8'hFF, "R3 mem0");

        // R5 / R10: page 2
        ld_begin(9'h040);
        ld_put(8'h55); ld_put(8'h66);
        copy_bad(9'h040, 2, "R5 eoff");
        copy_bad(9'h060, 1, "R5 addr");
        mem_expect(64, 8'hFF, "R5 mem");
        copy_ok(9'h040, 1, 2 + PC, "R5 then ok");
        mem_expect(64, 8'h55, "R4 p2b0");
        mem_expect(65, 8'h66, "R4 p2b1");
        copy_bad(9'h040, 1, "R10 repeat");
        ld_begin(9'h040);
        copy_bad(9'h040, 0, "R5 empty");

        // R8 / R6: modes
        md_set(6, 1);
        md_expect(6, 1, "R8 set lock");
        md_set(6, 0);
        md_expect(6, 1, "R8 no return");
        md_set(6, 2);
        md_expect(6, 1, "R8 no switch");
        md_set(7, 3);
        md_expect(7, 0, "R8 reserved");
        ld_begin(9'h0C0);
        ld_put(8'h12);
        copy_ok(9'h0C0, 0, 1 + PC, "R6 busy len");
        mem_expect(192, 8'hFF, "R6 locked");

        // R7: clear-only page 7
        md_set(7, 2);
        md_expect(7, 2, "R8 set zero");
        ld_begin(9'h0E0);
        ld_put(8'hF0); ld_put(8'h3C);
        copy_ok(9'h0E0, 1, 2 + PC, "R7 first");
        mem_expect(224, 8'hF0, "R7 b0 first");
        mem_expect(225, 8'h3C, "R7 b1 first");
        ld_begin(9'h0E0);
        ld_put(8'h0F); ld_put(8'hFF);
        copy_ok(9'h0E0, 1, 2 + PC, "R7 second");
        mem_expect(224, 8'h00, "R7 and b0");
        mem_expect(225, 8'h3C, "R7 and b1");

        // R9: requests while busy, page 8
        ld_begin(9'h100);
        ld_put(8'h99);
        cp_req  = 1'b1;
        cp_addr = 9'h100;
        cp_eoff = 5'd0;
        @(negedge clk);
        cp_req = 1'b0;
        chk("R9 busy up", int'(busy), 1);
        ld_start = 1'b1;
        ld_addr  = 9'h120;
        @(negedge clk);
        ld_start = 1'b0;
        chk("R9 reject ld", int'(req_reject), 1);
        chk("R9 tgt kept", int'(tgt_addr), 9'h100);
        ld_put(8'h55);
        cp_req = 1'b1;
        @(negedge clk);
        cp_req = 1'b0;
        chk("R9 reject cp", int'(req_reject), 1);
        while (busy) @(negedge clk);
        sp_expect(0, 8'h99, "R9 sp kept");
        mem_expect(256, 8'h99, "R9 mem");
        mem_expect(288, 8'hFF, "R9 no copy");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule